// File: doc/BRIEF.md
# Load Address and Data Aligner

This block sits in the load path of a processor core. When a load or port-input operation issues, it adds a sign-extended 16-bit displacement to a base register value. It then forces the low address bits to zero according to the access size and raises a read request toward memory or port space.

When the read response returns with a 32-bit word, the block selects the addressed byte or halfword lane. It sign-extends that value to 32 bits and presents it for write-back to the destination register, marked by a one-cycle valid strobe. Misaligned addresses never fault; they are masked down to natural alignment. Port-input accesses reuse the word-load path, and only the port flag tells them apart from a memory read. Only one request is outstanding at a time.

Top module: `load_aligner`

## Requirements
- R1: For a byte access (`size_i` = 2'b00, `port_sel_i` = 0), `addr_o` equals `base_i` plus `disp_i` sign-extended to 32 bits, modulo 2^32, with no bits masked.
- R2: For a halfword access (`size_i` = 2'b01, `port_sel_i` = 0), `addr_o` is the same sum with bit 0 forced to 0.
- R3: For a word access (`size_i` = 2'b10 or 2'b11), `addr_o` is the same sum with bits 1 and 0 forced to 0.
- R4: When `port_sel_i` = 1, the access is treated as a word access whatever `size_i` holds, and `port_o` is 1. When `port_sel_i` = 0, `port_o` is 0.
- R5: When `start_i` is high while no request is pending, `req_o` rises at the next clock edge. At that same edge `addr_o` and `port_o` take their values for the access. `req_o` stays high until an edge at which `rsp_valid_i` is high, and falls at that edge.
- R6: `start_i` has no effect while a request is pending: `addr_o`, `port_o`, and the later write-back value all stay those of the pending access.
- R7: For a byte access, the write-back value is `rdata_i[8*a+7:8*a]` sign-extended to 32 bits, where a = `addr_o[1:0]` (little-endian lanes).
- R8: For a halfword access, the write-back value is `rdata_i[15:0]` when `addr_o[1]` = 0, or `rdata_i[31:16]` when it is 1, sign-extended to 32 bits.
- R9: For word and port accesses, the write-back value equals `rdata_i` unchanged.
- R10: `wb_valid_o` is a one-cycle pulse in the cycle after the response edge, with `wb_data_o` valid alongside it. `rsp_valid_i` while no request is pending has no effect.
- R11: After reset, `req_o`, `port_o` and `wb_valid_o` are 0, and `addr_o` and `wb_data_o` are all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Issue a load or port input |
| base_i | input | 32 | Base register value |
| disp_i | input | 16 | Signed displacement |
| size_i | input | 2 | 00 byte, 01 halfword, 1x word |
| port_sel_i | input | 1 | 1 selects port space (word access) |
| rsp_valid_i | input | 1 | Read response present |
| rdata_i | input | 32 | Returned read word |
| req_o | output | 1 | Read request pending |
| addr_o | output | 32 | Aligned address |
| port_o | output | 1 | Request targets port space |
| wb_valid_o | output | 1 | Write-back strobe |
| wb_data_o | output | 32 | Write-back value |

## Verification
The assertions assume that `rsp_valid_i` is only meaningful while `req_o` is high. They also assume that `size_i` and `port_sel_i` are sampled only in the cycle in which `start_i` is accepted. The bench holds a response back for zero to a few cycles and changes the inputs only on falling edges. It raises `start_i` and `rsp_valid_i` out of turn only in the two tests that check those inputs are ignored.

// File: rtl/load_align_pkg.sv
package load_align_pkg;
  localparam logic [1:0] SZ_BYTE = 2'b00;
  localparam logic [1:0] SZ_HALF = 2'b01;
  localparam logic [1:0] SZ_WORD = 2'b10;
endpackage

// File: rtl/la_addr_gen.sv
module la_addr_gen
  import load_align_pkg::*;
#(
  parameter int AW     = 32,
  parameter int DISP_W = 16
) (
  input  logic [AW-1:0]     base_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic [1:0]        size_i,
  input  logic              port_i,
  output logic [AW-1:0]     addr_o,
  output logic [1:0]        size_o
);
  logic [AW-1:0] disp_ext;
  logic [AW-1:0] sum;
  logic [AW-1:0] mask;

  assign disp_ext = {{(AW-DISP_W){disp_i[DISP_W-1]}}, disp_i};
  assign sum      = base_i + disp_ext;

  // port input always rides the word path
  always_comb begin
    if (port_i || size_i[1]) size_o = SZ_WORD;
    else                     size_o = size_i;
  end

  always_comb begin
    mask = '1;
    case (size_o)
      SZ_HALF: mask[0]   = 1'b0;
      SZ_WORD: mask[1:0] = 2'b00;
      default: ;
    endcase
  end

  assign addr_o = sum & mask;
endmodule

// File: rtl/la_lane_extract.sv
module la_lane_extract
  import load_align_pkg::*;
#(
  parameter int DW = 32,
  localparam int NB = DW / 8,
  localparam int NH = DW / 16,
  localparam int LW = $clog2(NB)
) (
  input  logic [1:0]    size_i,
  input  logic [LW-1:0] lane_i,
  input  logic [DW-1:0] rdata_i,
  output logic [DW-1:0] data_o
);
  logic [7:0]  bytes [NB];
  logic [15:0] halves[NH];

  for (genvar b = 0; b < NB; b++) begin : g_byte
    assign bytes[b] = rdata_i[8*b +: 8];
  end
  for (genvar h = 0; h < NH; h++) begin : g_half
    assign halves[h] = rdata_i[16*h +: 16];
  end

  logic [7:0]  sel_b;
  logic [15:0] sel_h;
  assign sel_b = bytes[lane_i];
  assign sel_h = halves[lane_i[LW-1:1]];

  always_comb begin
    case (size_i)
      SZ_BYTE: data_o = {{(DW-8){sel_b[7]}}, sel_b};
      SZ_HALF: data_o = {{(DW-16){sel_h[15]}}, sel_h};
      default: data_o = rdata_i;
    endcase
  end
endmodule

// File: rtl/la_req_ctrl.sv
module la_req_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic rsp_valid_i,
  output logic accept_o,
  output logic done_o,
  output logic req_o,
  output logic wb_valid_o
);
  logic req_q, wb_q;

  assign accept_o = start_i & ~req_q;
  assign done_o   = rsp_valid_i & req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= 1'b0;
      wb_q  <= 1'b0;
    end else begin
      wb_q <= done_o;
      if (accept_o)    req_q <= 1'b1;
      else if (done_o) req_q <= 1'b0;
    end
  end

  assign req_o      = req_q;
  assign wb_valid_o = wb_q;
endmodule

// File: rtl/load_aligner.sv
module load_aligner
  import load_align_pkg::*;
#(
  parameter int AW     = 32,
  parameter int DW     = 32,
  parameter int DISP_W = 16,
  localparam int LW    = $clog2(DW / 8)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [AW-1:0]     base_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic [1:0]        size_i,
  input  logic              port_sel_i,
  input  logic              rsp_valid_i,
  input  logic [DW-1:0]     rdata_i,
  output logic              req_o,
  output logic [AW-1:0]     addr_o,
  output logic              port_o,
  output logic              wb_valid_o,
  output logic [DW-1:0]     wb_data_o
);
  logic          accept, done;
  logic [AW-1:0] addr_n;
  logic [1:0]    size_n;
  logic [DW-1:0] ext_data;

  logic [AW-1:0] addr_q;
  logic          port_q;
  logic [LW-1:0] lane_q;
  logic [1:0]    size_q;
  logic [DW-1:0] wb_q;

  la_req_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .rsp_valid_i (rsp_valid_i),
    .accept_o    (accept),
    .done_o      (done),
    .req_o       (req_o),
    .wb_valid_o  (wb_valid_o)
  );

  la_addr_gen #(.AW(AW), .DISP_W(DISP_W)) u_addr (
    .base_i (base_i),
    .disp_i (disp_i),
    .size_i (size_i),
    .port_i (port_sel_i),
    .addr_o (addr_n),
    .size_o (size_n)
  );

  la_lane_extract #(.DW(DW)) u_ext (
    .size_i  (size_q),
    .lane_i  (lane_q),
    .rdata_i (rdata_i),
    .data_o  (ext_data)
  );

  // lane and size held from request until response
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      port_q <= 1'b0;
      lane_q <= '0;
      size_q <= SZ_WORD;
      wb_q   <= '0;
    end else begin
      if (accept) begin
        addr_q <= addr_n;
        port_q <= port_sel_i;
        lane_q <= addr_n[LW-1:0];
        size_q <= size_n;
      end
      if (done) wb_q <= ext_data;
    end
  end

  assign addr_o    = addr_q;
  assign port_o    = port_q;
  assign wb_data_o = wb_q;
endmodule

// File: rtl/load_aligner_chk.sv
module load_aligner_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        start_i,
  input logic [1:0]  size_i,
  input logic        port_sel_i,
  input logic        rsp_valid_i,
  input logic        req_o,
  input logic [31:0] addr_o,
  input logic        port_o,
  input logic        wb_valid_o
);
  p_req_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && !rsp_valid_i |=> req_o);

  p_req_rise_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_o && start_i |=> req_o);

  p_hold_addr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && !rsp_valid_i |=> $stable(addr_o) && $stable(port_o));

  p_half_align_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_o) && $past(size_i == 2'b01 && !port_sel_i) |-> !addr_o[0]);

  p_word_align_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_o) && $past(size_i[1] || port_sel_i) |-> addr_o[1:0] == 2'b00);

  p_port_flag_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_o) |-> port_o == $past(port_sel_i));

  p_wb_follows_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && rsp_valid_i |=> wb_valid_o && !req_o);

  p_wb_cause_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o |-> $past(req_o && rsp_valid_i));

  p_wb_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o |=> !wb_valid_o);
endmodule

bind load_aligner load_aligner_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .size_i      (size_i),
  .port_sel_i  (port_sel_i),
  .rsp_valid_i (rsp_valid_i),
  .req_o       (req_o),
  .addr_o      (addr_o),
  .port_o      (port_o),
  .wb_valid_o  (wb_valid_o)
);

// File: tb/load_aligner_bench.sv
module load_aligner_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] base = '0;
  logic [15:0] disp = '0;
  logic [1:0]  size = '0;
  logic        psel = 1'b0;
  logic        rsp = 1'b0;
  logic [31:0] rdata = '0;
  logic        req, port, wbv;
  logic [31:0] addr, wbd;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  load_aligner u_load_aligner (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .base_i(base), .disp_i(disp),
    .size_i(size), .port_sel_i(psel), .rsp_valid_i(rsp), .rdata_i(rdata),
    .req_o(req), .addr_o(addr), .port_o(port), .wb_valid_o(wbv), .wb_data_o(wbd)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_addr(logic [31:0] b, logic [15:0] d,
                                           logic [1:0] s, logic p);
    logic [31:0] a;
    a = b + {{16{d[15]}}, d};
    if (p || s[1]) a[1:0] = 2'b00;
    else if (s == 2'b01) a[0] = 1'b0;
    return a;
  endfunction

  function automatic logic [31:0] exp_data(logic [31:0] a, logic [1:0] s,
                                           logic p, logic [31:0] w);
    logic [7:0]  b8;
    logic [15:0] h16;
    if (p || s[1]) return w;
    if (s == 2'b00) begin
      b8 = w[8*a[1:0] +: 8];
      return {{24{b8[7]}}, b8};
    end
    h16 = a[1] ? w[31:16] : w[15:0];
    return {{16{h16[15]}}, h16};
  endfunction

  // one full access: issue, wait, respond, check write-back
  task automatic do_load(string tag, logic [31:0] b, logic [15:0] d, logic [1:0] s,
                         logic p, logic [31:0] w, int dly);
    logic [31:0] ea;
    ea = exp_addr(b, d, s, p);
    @(negedge clk);
    base = b; disp = d; size = s; psel = p; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk({tag, " R5 req"}, {31'b0, req}, 32'd1);
    chk({tag, " addr"}, addr, ea);
    chk({tag, " R4 port"}, {31'b0, port}, {31'b0, p});
    for (int i = 0; i < dly; i++) begin
      @(negedge clk);
      chk({tag, " R5 hold"}, {31'b0, req}, 32'd1);
    end
    rsp = 1'b1; rdata = w;
    @(negedge clk);
    rsp = 1'b0; rdata = ~w;
    chk({tag, " R5 drop"}, {31'b0, req}, 32'd0);
    chk({tag, " R10 wbv"}, {31'b0, wbv}, 32'd1);
    chk({tag, " data"}, wbd, exp_data(ea, s, p, w));
    @(negedge clk);
    chk({tag, " R10 pulse"}, {31'b0, wbv}, 32'd0);
  endtask

  task automatic t_reset;
    chk("R11 req", {31'b0, req}, 32'd0);
    chk("R11 port", {31'b0, port}, 32'd0);
    chk("R11 wbv", {31'b0, wbv}, 32'd0);
    chk("R11 addr", addr, 32'd0);
    chk("R11 wbd", wbd, 32'd0);
  endtask

  task automatic t_byte;
    do_load("R1 R7 b80 lane3", 32'h0000_1000, 16'h0003, 2'b00, 1'b0, 32'h80AA_5511, 0);
    do_load("R1 R7 neg disp", 32'h0000_1000, 16'hFFFF, 2'b00, 1'b0, 32'h7F00_0000, 1);
    do_load("R1 R7 wrap", 32'hFFFF_FFFE, 16'h0003, 2'b00, 1'b0, 32'h1234_56F0, 2);
    for (int i = 0; i < 8; i++)
      do_load("R1 R7 rand", $urandom, 16'($urandom), 2'b00, 1'b0, $urandom, i % 3);
  endtask

  task automatic t_half;
    do_load("R2 R8 h8000 up", 32'h0000_2002, 16'h0001, 2'b01, 1'b0, 32'h8000_7FFF, 0);
    do_load("R2 R8 low", 32'h0000_2000, 16'h0001, 2'b01, 1'b0, 32'h8000_7FFF, 1);
    do_load("R2 R8 low neg", 32'h0000_2000, 16'h0000, 2'b01, 1'b0, 32'h0000_8000, 0);
    for (int i = 0; i < 8; i++)
      do_load("R2 R8 rand", $urandom, 16'($urandom), 2'b01, 1'b0, $urandom, i % 2);
  endtask

  task automatic t_word;
    do_load("R3 R9 mask", 32'h0000_3000, 16'h0007, 2'b10, 1'b0, 32'h8765_4321, 0);
    do_load("R3 R9 sz11", 32'h0000_3001, 16'hFFF2, 2'b11, 1'b0, 32'hFFFF_8080, 1);
    for (int i = 0; i < 6; i++)
      do_load("R3 R9 rand", $urandom, 16'($urandom), 2'b10, 1'b0, $urandom, i % 3);
  endtask

  task automatic t_port;
    do_load("R4 R9 port byte", 32'h0000_4003, 16'h0000, 2'b00, 1'b1, 32'h0000_0080, 0);
    do_load("R4 R9 port half", 32'h0000_4001, 16'h0001, 2'b01, 1'b1, 32'h8000_8000, 2);
    for (int i = 0; i < 4; i++)
      do_load("R4 rand", $urandom, 16'($urandom), 2'($urandom), 1'b1, $urandom, i);
  endtask

  task automatic t_ignore_start;
    @(negedge clk);
    base = 32'h0000_5000; disp = 16'h0001; size = 2'b00; psel = 1'b0; start = 1'b1;
    @(negedge clk);
    base = 32'h0000_6002; disp = 16'h0000; size = 2'b10; psel = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R6 addr", addr, 32'h0000_5001);
    chk("R6 port", {31'b0, port}, 32'd0);
    rsp = 1'b1; rdata = 32'h1122_80FF;
    @(negedge clk);
    rsp = 1'b0;
    chk("R6 data", wbd, 32'hFFFF_FF80);
    @(negedge clk);
  endtask

  task automatic t_stray_rsp;
    @(negedge clk);
    rsp = 1'b1; rdata = 32'hDEAD_BEEF;
    @(negedge clk);
    rsp = 1'b0;
    chk("R10 stray wbv", {31'b0, wbv}, 32'd0);
    chk("R10 stray req", {31'b0, req}, 32'd0);
    @(negedge clk);
    chk("R10 stray wbv2", {31'b0, wbv}, 32'd0);
  endtask

  initial begin
    void'($urandom(7));
    #1;
    t_reset;
    #10 rst_n = 1'b1;
    t_byte;
    t_half;
    t_word;
    t_port;
    t_ignore_start;
    t_stray_rsp;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule